// File: doc/BRIEF.md
# Masked Time and Date Alarm Comparator

This block compares a running BCD time of day and calendar date with a programmed alarm. The alarm is held in two words. The time word carries seconds, minutes, hours and an AM/PM bit. The calendar word carries the month and the day of the month. Each field has its own enable bit. A field whose enable is clear is left out of the comparison. When every enabled field equals the current value at a one-second tick, a sticky alarm flag is raised. It stays raised until a clear command is given.

The block also checks the alarm entries themselves. A time entry is non-valid when an enabled field holds a digit above nine or lies outside the range of its field. A calendar entry is non-valid under the same rule. An entry that is non-valid is reported on its own output, and that part of the alarm can never match. The time and date counters are produced elsewhere and arrive here as inputs.

Top module: `tdalarm_cmp`

## Requirements
- R1: The time alarm word `timeAlmWord` is laid out as follows: seconds BCD in bits 6:0 with enable at bit 7, minutes BCD in bits 14:8 with enable at bit 15, hours BCD in bits 21:16, the PM bit at bit 22 (1 = PM) and the hour enable at bit 23.
- R2: The calendar alarm word `calAlmWord` carries the month BCD in bits 20:16 with enable at bit 23, and the date BCD in bits 29:24 with enable at bit 31. A mismatch in an enabled calendar field blocks the alarm.
- R3: At a rising edge of `clk` where a tick is evaluated and every enabled field matches, `alarmFlag` is 1 after that edge. The flag never rises at an edge where no tick is evaluated.
- R4: A field whose enable bit is 0 counts as matching whatever its value. With all five enables at 0 the alarm never fires.
- R5: `alarmFlag` stays at 1 until `clrAlarm` is sampled high, and it is 0 after that edge. If a tick with a match and `clrAlarm` arrive in the same cycle, the flag is set.
- R6: A tick is evaluated only on the cycle where `secTick` rises. After a clear, the flag stays 0 while `secTick` is held high, even though the match persists.
- R7: `timeAlmBad` is 1 when an enabled time field has a BCD digit above 9, when seconds or minutes exceed 59, when the hour exceeds 23 in 24-hour mode (`hour12`=0), or when the hour is outside 01 to 12 in 12-hour mode. Fields whose enable is 0 are not checked.
- R8: `calAlmBad` is 1 when an enabled calendar field has a BCD digit above 9, when the month lies outside 01 to 12, or when the date lies outside 01 to 31. Fields whose enable is 0 are not checked.
- R9: While `timeAlmBad` or `calAlmBad` is 1, the alarm never fires, even when the raw values are equal.
- R10: The PM bit is compared with `curPm` only when `hour12` is 1. In 24-hour mode it is ignored.
- R11: While `rstN` is low, `alarmFlag` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hour12 | input | 1 | 1 selects 12-hour mode, 0 selects 24-hour mode |
| timeAlmWord | input | 24 | Time alarm fields and their enables |
| calAlmWord | input | 32 | Calendar alarm fields and their enables |
| curSec | input | 7 | Current seconds, BCD |
| curMin | input | 7 | Current minutes, BCD |
| curHour | input | 6 | Current hour, BCD |
| curPm | input | 1 | Current PM indicator |
| curMonth | input | 5 | Current month, BCD |
| curDate | input | 6 | Current day of month, BCD |
| secTick | input | 1 | One-second tick; its rising edge triggers an evaluation |
| clrAlarm | input | 1 | Write-one-to-clear command for the alarm flag |
| alarmFlag | output | 1 | Sticky alarm flag |
| timeAlmBad | output | 1 | The time alarm entry is non-valid |
| calAlmBad | output | 1 | The calendar alarm entry is non-valid |

## Verification
The bench builds the block with its default parameters: BCD ceilings of 59, 23, 12, 12 and 31, and the tick taken on its rising edge. These settings put the exact range boundaries within reach: 59 against 5A, 23 against 24 in 24-hour mode, and 12 against 13 or 00 in 12-hour mode. Holding `secTick` high over several cycles exercises the single evaluation per tick, and it shows that a clear is not undone by a match that persists.

// File: rtl/tdalarm_pkg.sv
`timescale 1ns/1ps
package tdalarm_pkg;
  localparam int NUM_FIELDS = 5;
  localparam int F_SEC   = 0;
  localparam int F_MIN   = 1;
  localparam int F_HOUR  = 2;
  localparam int F_MONTH = 3;
  localparam int F_DATE  = 4;
  localparam int NUM_TIME_FIELDS = 3;

  typedef struct packed {
    logic evalStb;
    logic clrStb;
  } ctl_strobe_t;

  function automatic logic bcdInRange(input logic [7:0] v,
                                      input logic [7:0] lo,
                                      input logic [7:0] hi);
    return (v[3:0] <= 4'd9) && (v[7:4] <= 4'd9) && (v >= lo) && (v <= hi);
  endfunction
endpackage

// File: rtl/tdalarm_ctl.sv
`timescale 1ns/1ps
module tdalarm_ctl
  import tdalarm_pkg::*;
#(
  parameter bit EDGE_TICK = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        secTick,
  input  logic        clrAlarm,
  output ctl_strobe_t stb
);
  logic evalNow;

  generate
    if (EDGE_TICK) begin : g_edge
      logic prevTick;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) prevTick <= 1'b0;
        else       prevTick <= secTick;
      end
      assign evalNow = secTick & ~prevTick;
    end else begin : g_level
      assign evalNow = secTick;
    end
  endgenerate

  always_comb begin
    stb.evalStb = evalNow;
    stb.clrStb  = clrAlarm;
  end
endmodule

// File: rtl/tdalarm_dp.sv
`timescale 1ns/1ps
module tdalarm_dp
  import tdalarm_pkg::*;
#(
  parameter logic [7:0] SEC_MAX    = 8'h59,
  parameter logic [7:0] HOUR24_MAX = 8'h23,
  parameter logic [7:0] HOUR12_MAX = 8'h12,
  parameter logic [7:0] MONTH_MAX  = 8'h12,
  parameter logic [7:0] DATE_MAX   = 8'h31
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        hour12,
  input  logic [23:0] timeWord,
  input  logic [31:0] calWord,
  input  logic [6:0]  curSec,
  input  logic [6:0]  curMin,
  input  logic [5:0]  curHour,
  input  logic        curPm,
  input  logic [4:0]  curMonth,
  input  logic [5:0]  curDate,
  input  ctl_strobe_t stb,
  output logic        alarmFlag,
  output logic        timeBad,
  output logic        calBad
);
  logic [7:0] almVal [NUM_FIELDS];
  logic [7:0] curVal [NUM_FIELDS];
  logic [7:0] loVal  [NUM_FIELDS];
  logic [7:0] hiVal  [NUM_FIELDS];
  logic [NUM_FIELDS-1:0] fieldEn;
  logic [NUM_FIELDS-1:0] fieldOk;
  logic [NUM_FIELDS-1:0] fieldHit;
  logic pmAgree;
  logic allHit;

  // alarm field extraction (positions fixed by the word layout)
  assign almVal[F_SEC]   = {1'b0, timeWord[6:0]};
  assign almVal[F_MIN]   = {1'b0, timeWord[14:8]};
  assign almVal[F_HOUR]  = {2'b0, timeWord[21:16]};
  assign almVal[F_MONTH] = {3'b0, calWord[20:16]};
  assign almVal[F_DATE]  = {2'b0, calWord[29:24]};

  assign fieldEn[F_SEC]   = timeWord[7];
  assign fieldEn[F_MIN]   = timeWord[15];
  assign fieldEn[F_HOUR]  = timeWord[23];
  assign fieldEn[F_MONTH] = calWord[23];
  assign fieldEn[F_DATE]  = calWord[31];

  assign curVal[F_SEC]   = {1'b0, curSec};
  assign curVal[F_MIN]   = {1'b0, curMin};
  assign curVal[F_HOUR]  = {2'b0, curHour};
  assign curVal[F_MONTH] = {3'b0, curMonth};
  assign curVal[F_DATE]  = {2'b0, curDate};

  assign loVal[F_SEC]   = 8'h00;
  assign loVal[F_MIN]   = 8'h00;
  assign loVal[F_HOUR]  = hour12 ? 8'h01 : 8'h00;
  assign loVal[F_MONTH] = 8'h01;
  assign loVal[F_DATE]  = 8'h01;

  assign hiVal[F_SEC]   = SEC_MAX;
  assign hiVal[F_MIN]   = SEC_MAX;
  assign hiVal[F_HOUR]  = hour12 ? HOUR12_MAX : HOUR24_MAX;
  assign hiVal[F_MONTH] = MONTH_MAX;
  assign hiVal[F_DATE]  = DATE_MAX;

  // meridiem only matters in 12-hour mode
  assign pmAgree = !hour12 || (timeWord[22] == curPm);

  generate
    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
      logic valEq;
      assign fieldOk[i] = !fieldEn[i] || bcdInRange(almVal[i], loVal[i], hiVal[i]);
      if (i == F_HOUR) begin : g_hr
        assign valEq = (almVal[i] == curVal[i]) && pmAgree;
      end else begin : g_plain
        assign valEq = (almVal[i] == curVal[i]);
      end
      assign fieldHit[i] = !fieldEn[i] || valEq;
    end
  endgenerate

  assign timeBad = !(&fieldOk[NUM_TIME_FIELDS-1:0]);
  assign calBad  = !(&fieldOk[NUM_FIELDS-1:NUM_TIME_FIELDS]);
  assign allHit  = (|fieldEn) && !timeBad && !calBad && (&fieldHit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       alarmFlag <= 1'b0;
    else if (stb.evalStb && allHit)  alarmFlag <= 1'b1;
    else if (stb.clrStb)             alarmFlag <= 1'b0;
  end
endmodule

// File: rtl/tdalarm_cmp.sv
`timescale 1ns/1ps
module tdalarm_cmp
  import tdalarm_pkg::*;
#(
  parameter logic [7:0] SEC_MAX    = 8'h59,
  parameter logic [7:0] HOUR24_MAX = 8'h23,
  parameter logic [7:0] HOUR12_MAX = 8'h12,
  parameter logic [7:0] MONTH_MAX  = 8'h12,
  parameter logic [7:0] DATE_MAX   = 8'h31,
  parameter bit         EDGE_TICK  = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        hour12,
  input  logic [23:0] timeAlmWord,
  input  logic [31:0] calAlmWord,
  input  logic [6:0]  curSec,
  input  logic [6:0]  curMin,
  input  logic [5:0]  curHour,
  input  logic        curPm,
  input  logic [4:0]  curMonth,
  input  logic [5:0]  curDate,
  input  logic        secTick,
  input  logic        clrAlarm,
  output logic        alarmFlag,
  output logic        timeAlmBad,
  output logic        calAlmBad
);
  ctl_strobe_t stb;

  tdalarm_ctl #(.EDGE_TICK(EDGE_TICK)) u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .secTick  (secTick),
    .clrAlarm (clrAlarm),
    .stb      (stb)
  );

  tdalarm_dp #(
    .SEC_MAX    (SEC_MAX),
    .HOUR24_MAX (HOUR24_MAX),
    .HOUR12_MAX (HOUR12_MAX),
    .MONTH_MAX  (MONTH_MAX),
    .DATE_MAX   (DATE_MAX)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .hour12    (hour12),
    .timeWord  (timeAlmWord),
    .calWord   (calAlmWord),
    .curSec    (curSec),
    .curMin    (curMin),
    .curHour   (curHour),
    .curPm     (curPm),
    .curMonth  (curMonth),
    .curDate   (curDate),
    .stb       (stb),
    .alarmFlag (alarmFlag),
    .timeBad   (timeAlmBad),
    .calBad    (calAlmBad)
  );
endmodule

// File: rtl/tdalarm_chk.sv
`timescale 1ns/1ps
module tdalarm_chk (
  input logic        clk,
  input logic        rstN,
  input logic        secTick,
  input logic        clrAlarm,
  input logic [23:0] timeAlmWord,
  input logic [31:0] calAlmWord,
  input logic        alarmFlag,
  input logic        timeAlmBad,
  input logic        calAlmBad
);
  logic noTimeEn, noCalEn;
  assign noTimeEn = !(timeAlmWord[7] || timeAlmWord[15] || timeAlmWord[23]);
  assign noCalEn  = !(calAlmWord[23] || calAlmWord[31]);

  // R3
  rise_needs_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(alarmFlag) |-> $past(secTick));

  // R5
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (alarmFlag && !clrAlarm) |=> alarmFlag);

  // R5
  clear_takes_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clrAlarm && !secTick) |=> !alarmFlag);

  // R4
  no_enable_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (noTimeEn && noCalEn && !alarmFlag) |=> !alarmFlag);

  // R9
  bad_time_blocks_chk: assert property (@(posedge clk) disable iff (!rstN)
    (timeAlmBad && !alarmFlag) |=> !alarmFlag);

  // R9
  bad_cal_blocks_chk: assert property (@(posedge clk) disable iff (!rstN)
    (calAlmBad && !alarmFlag) |=> !alarmFlag);

  // R7
  time_bad_needs_en_chk: assert property (@(posedge clk) disable iff (!rstN)
    noTimeEn |-> !timeAlmBad);

  // R8
  cal_bad_needs_en_chk: assert property (@(posedge clk) disable iff (!rstN)
    noCalEn |-> !calAlmBad);
endmodule

bind tdalarm_cmp tdalarm_chk u_chk (.*);

// File: tb/tb_tdalarm_cmp.sv
`timescale 1ns/1ps
module tb_tdalarm_cmp;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hour12 = 1'b0;
  logic [23:0] timeAlmWord = '0;
  logic [31:0] calAlmWord = '0;
  logic [6:0]  curSec = '0;
  logic [6:0]  curMin = '0;
  logic [5:0]  curHour = '0;
  logic        curPm = 1'b0;
  logic [4:0]  curMonth = '0;
  logic [5:0]  curDate = '0;
  logic        secTick = 1'b0;
  logic        clrAlarm = 1'b0;
  logic        alarmFlag, timeAlmBad, calAlmBad;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk; // 250 MHz

  tdalarm_cmp dut (.*);

  function automatic logic [23:0] tw(input logic [6:0] s, input logic sEn,
                                     input logic [6:0] m, input logic mEn,
                                     input logic [5:0] h, input logic pm, input logic hEn);
    return {hEn, pm, h, mEn, m, sEn, s};
  endfunction

  function automatic logic [31:0] cw(input logic [4:0] mo, input logic moEn,
                                     input logic [5:0] d, input logic dEn);
    return {dEn, 1'b0, d, moEn, 2'b00, mo, 16'h0000};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tickPulse();
    @(negedge clk) secTick = 1'b1;
    @(negedge clk) secTick = 1'b0;
  endtask

  task automatic clearCmd();
    @(negedge clk) clrAlarm = 1'b1;
    @(negedge clk) clrAlarm = 1'b0;
  endtask

  task automatic blank();
    @(negedge clk);
    hour12 = 0; timeAlmWord = '0; calAlmWord = '0;
    curSec = '0; curMin = '0; curHour = '0; curPm = 0; curMonth = '0; curDate = '0;
  endtask

  task automatic t_reset();
    #1;
    chk("R11 flag in reset", alarmFlag, 0);
    chk("R7 time bad in reset", timeAlmBad, 0);
    chk("R8 cal bad in reset", calAlmBad, 0);
    @(negedge clk) rstN = 1'b1;
  endtask

  task automatic t_secMatch();
    blank();
    timeAlmWord = tw(7'h30, 1, 7'h00, 0, 6'h00, 0, 0);
    curSec = 7'h30;
    @(negedge clk);
    chk("R3 no flag before tick", alarmFlag, 0);
    tickPulse();
    chk("R1 R3 seconds match sets flag", alarmFlag, 1);
  endtask

  task automatic t_sticky();
    curSec = 7'h31;
    tickPulse();
    chk("R5 flag sticky on mismatch tick", alarmFlag, 1);
    clearCmd();
    chk("R5 clear drops flag", alarmFlag, 0);
    tickPulse();
    chk("R3 mismatch tick leaves flag low", alarmFlag, 0);
  endtask

  task automatic t_oncePerTick();
    blank();
    timeAlmWord = tw(7'h45, 1, 7'h00, 0, 6'h00, 0, 0);
    curSec = 7'h45;
    @(negedge clk) secTick = 1'b1;
    @(negedge clk);
    chk("R6 held tick sets flag", alarmFlag, 1);
    clrAlarm = 1'b1;
    @(negedge clk) clrAlarm = 1'b0;
    chk("R6 clear during held tick", alarmFlag, 0);
    repeat (4) @(negedge clk);
    chk("R6 held tick not re-evaluated", alarmFlag, 0);
    secTick = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_noEnable();
    blank();
    timeAlmWord = tw(7'h10, 0, 7'h20, 0, 6'h05, 0, 0);
    calAlmWord  = cw(5'h03, 0, 6'h04, 0);
    curSec = 7'h10; curMin = 7'h20; curHour = 6'h05; curMonth = 5'h03; curDate = 6'h04;
    tickPulse();
    chk("R4 no enables never fires", alarmFlag, 0);
  endtask

  task automatic t_disabledIgnored();
    blank();
    timeAlmWord = tw(7'h11, 1, 7'h59, 0, 6'h00, 0, 0);
    calAlmWord  = cw(5'h09, 0, 6'h00, 0);
    curSec = 7'h11; curMin = 7'h02; curMonth = 5'h01; curDate = 6'h01;
    tickPulse();
    chk("R4 disabled fields ignored", alarmFlag, 1);
    clearCmd();
  endtask

  task automatic t_fullMatch();
    blank();
    timeAlmWord = tw(7'h56, 1, 7'h34, 1, 6'h12, 0, 1);
    calAlmWord  = cw(5'h07, 1, 6'h19, 1);
    curSec = 7'h56; curMin = 7'h34; curHour = 6'h12; curMonth = 5'h07; curDate = 6'h19;
    tickPulse();
    chk("R1 R2 all fields match", alarmFlag, 1);
    clearCmd();
    curDate = 6'h18;
    tickPulse();
    chk("R2 date mismatch blocks", alarmFlag, 0);
    curDate = 6'h19; curMonth = 5'h08;
    tickPulse();
    chk("R2 month mismatch blocks", alarmFlag, 0);
  endtask

  task automatic t_ampm();
    blank();
    hour12 = 1;
    timeAlmWord = tw(7'h00, 0, 7'h00, 0, 6'h08, 1, 1);
    curHour = 6'h08; curPm = 0;
    tickPulse();
    chk("R10 PM differs in 12h mode", alarmFlag, 0);
    curPm = 1;
    tickPulse();
    chk("R10 PM agrees in 12h mode", alarmFlag, 1);
    clearCmd();
    hour12 = 0; curPm = 0;
    tickPulse();
    chk("R10 PM ignored in 24h mode", alarmFlag, 1);
    clearCmd();
  endtask

  task automatic t_timeValid();
    blank();
    timeAlmWord = tw(7'h59, 1, 7'h59, 1, 6'h23, 0, 1); #1;
    chk("R7 59:59 hour 23 valid", timeAlmBad, 0);
    timeAlmWord = tw(7'h5A, 1, 7'h00, 0, 6'h00, 0, 0); #1;
    chk("R7 non-BCD seconds", timeAlmBad, 1);
    timeAlmWord = tw(7'h5A, 0, 7'h60, 0, 6'h00, 0, 0); #1;
    chk("R7 disabled bad fields unchecked", timeAlmBad, 0);
    timeAlmWord = tw(7'h00, 0, 7'h60, 1, 6'h00, 0, 0); #1;
    chk("R7 minutes 60", timeAlmBad, 1);
    timeAlmWord = tw(7'h00, 0, 7'h00, 0, 6'h24, 0, 1); #1;
    chk("R7 hour 24 in 24h", timeAlmBad, 1);
    @(negedge clk) hour12 = 1;
    timeAlmWord = tw(7'h00, 0, 7'h00, 0, 6'h13, 0, 1); #1;
    chk("R7 hour 13 in 12h", timeAlmBad, 1);
    timeAlmWord = tw(7'h00, 0, 7'h00, 0, 6'h00, 0, 1); #1;
    chk("R7 hour 00 in 12h", timeAlmBad, 1);
    timeAlmWord = tw(7'h00, 0, 7'h00, 0, 6'h12, 0, 1); #1;
    chk("R7 hour 12 in 12h", timeAlmBad, 0);
  endtask

  task automatic t_calValid();
    blank();
    calAlmWord = cw(5'h12, 1, 6'h31, 1); #1;
    chk("R8 month 12 date 31 valid", calAlmBad, 0);
    calAlmWord = cw(5'h13, 1, 6'h01, 0); #1;
    chk("R8 month 13", calAlmBad, 1);
    calAlmWord = cw(5'h00, 1, 6'h01, 0); #1;
    chk("R8 month 00", calAlmBad, 1);
    calAlmWord = cw(5'h01, 0, 6'h32, 1); #1;
    chk("R8 date 32", calAlmBad, 1);
    calAlmWord = cw(5'h01, 0, 6'h1B, 1); #1;
    chk("R8 non-BCD date", calAlmBad, 1);
    calAlmWord = cw(5'h1F, 0, 6'h00, 0); #1;
    chk("R8 disabled bad fields unchecked", calAlmBad, 0);
  endtask

  task automatic t_badSuppress();
    blank();
    timeAlmWord = tw(7'h5A, 1, 7'h00, 0, 6'h00, 0, 0);
    curSec = 7'h5A;
    tickPulse();
    chk("R9 bad time entry never fires", alarmFlag, 0);
    blank();
    calAlmWord = cw(5'h00, 1, 6'h00, 0);
    curMonth = 5'h00;
    tickPulse();
    chk("R9 bad calendar entry never fires", alarmFlag, 0);
  endtask

  task automatic t_setBeatsClear();
    blank();
    timeAlmWord = tw(7'h07, 1, 7'h00, 0, 6'h00, 0, 0);
    curSec = 7'h07;
    @(negedge clk) begin secTick = 1'b1; clrAlarm = 1'b1; end
    @(negedge clk) begin secTick = 1'b0; clrAlarm = 1'b0; end
    chk("R5 set wins over clear", alarmFlag, 1);
    clearCmd();
    chk("R5 clear afterwards", alarmFlag, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_secMatch();
    t_sticky();
    t_oncePerTick();
    t_noEnable();
    t_disabledIgnored();
    t_fullMatch();
    t_ampm();
    t_timeValid();
    t_calValid();
    t_badSuppress();
    t_setBeatsClear();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule